// File: doc/BRIEF.md
# Register-Controlled Cartridge Bank Mapper

This block turns every address on a 24-bit memory bus into a routing decision. It drives a target select and a target offset for each address. The address is split into an 8-bit bank and a 16-bit offset. The possible targets are the main program memory (flash or PSRAM), a fixed ROM, a battery-backed SRAM, and the mapper's own control registers. An address that reaches none of these is reported as unmapped. The decode itself is combinational. The only state is a bank of sixteen 8-bit control registers and a latched copy of the mapping controls taken from them.

Software reprograms the layout in two steps. It first writes the control registers through a one-byte window in each of the low sixteen banks, and these writes are only staged. It then writes register 0x0E with bit 7 set, and that commit copies the staged mapping bits into the live configuration. The next bus cycle decodes against the new layout. Because of this, a program running from mapped memory can rearrange several regions at once without passing through a half-built layout.

Top module: `cbm_mapper`

## Requirements
- R1: A write at offset 0x5000 of bank N, for N in 0x00..0x0F, stores the data in control register N. A read at that address reports select code 5 (control). The offset output equals N and `reg_rdata` holds the stored value.
- R2: Writing any register other than 0x0E, or writing 0x0E with bit 7 clear, leaves the live mapping unchanged.
- R3: Writing register 0x0E with bit 7 set copies bit 7 of registers 1, 2, 3, 5, 6, 7 and 8 into the live mapping. The new mapping is decoded from the next clock cycle onward.
- R4: After reset, every register reads 0x00 except registers 7 and 8, which read 0x80. The live mapping equals the one these values select.
- R5: Banks 0x10..0x17 at offsets 0x5000..0x5FFF select code 4 (SRAM). The offset is (bank & 7) * 0x1000 + (offset & 0xFFF).
- R6: Live bit 7 of register 1 chooses the main program target: 0 gives code 1 (flash) and 1 gives code 2 (PSRAM).
- R7: With live bit 7 of register 2 clear (linear layout), banks 0x00..0x7D and 0x80..0xFF at offsets 0x8000..0xFFFF reach the main target. The flash offset is (bank & 0x7F) * 0x8000 + (offset & 0x7FFF).
- R8: With live bit 7 of register 2 set (high layout), banks 0x40..0x7D and 0xC0..0xFF reach the main target across all 64 KiB. Banks 0x00..0x3F and 0x80..0xBF reach it only at offsets 0x8000 and above. The flash offset is (bank & 0x3F) * 0x10000 + offset.
- R9: PSRAM replaces the main decode over whole banks when these live bits hold: register 3 bit 7 set for banks 0x60..0x6F, register 5 bit 7 clear for banks 0x40..0x4F, and register 6 bit 7 clear for banks 0x50..0x5F.
- R10: Live bit 7 of register 7 set maps banks 0x00..0x1F at offsets 0x8000 and above to code 3 (fixed ROM). Register 8 does the same for banks 0x80..0x9F. The ROM offset is (bank & 0x1F) * 0x8000 + (offset & 0x7FFF).
- R11: Banks 0x20..0x3F at offsets 0x6000..0x7FFF, and banks 0x70..0x77 at every offset, always select PSRAM.
- R12: Priority runs from lowest to highest: main decode, then the register 3, 5, 6, 7 and 8 overlays, then the fixed PSRAM regions, then the register and SRAM windows. An address that matches nothing gives code 0 (none) with offset 0.
- R13: Every PSRAM offset is the 24-bit value {bank, offset} taken modulo 2^PSRAM_AW, which is 512 KiB by default.
- R14: Bus writes outside the register window leave every control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 24 | Bus address, bank in bits 23:16 |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | Write data |
| tgt_sel | output | 3 | Target code: 0 none, 1 flash, 2 PSRAM, 3 ROM, 4 SRAM, 5 control |
| tgt_ofs | output | 24 | Offset inside the selected target |
| reg_rdata | output | 8 | Control register contents on a window hit, else 0 |

## Verification
The bench builds the block with its default parameters: sixteen 8-bit registers and a 19-bit PSRAM offset. The 19-bit width means a bank as low as 0x08 already wraps the PSRAM offset, so the modulo rule shows up in ordinary vectors. A vector table covers the layout that reset leaves in place. Directed steps then commit the high layout, the overlay-off settings and the PSRAM main source in turn. They also check that staged writes, uncommitted writes to register 0x0E and writes outside the window leave the decode and the registers unchanged. A second reset in the middle of the run confirms that the register values and the mapping return to their reset state.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int BANK_W = 8;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = BANK_W + OFF_W;
  localparam int KEY_BIT = 7;

  localparam logic [OFF_W-1:0] REG_WIN_OFF = 16'h5000;
  localparam logic [4:0]       SRAM_BANK_HI = 5'b00010;
  localparam logic [3:0]       SRAM_OFF_HI  = 4'h5;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_FLASH = 3'd1,
    TGT_PSRAM = 3'd2,
    TGT_ROM   = 3'd3,
    TGT_SRAM  = 3'd4,
    TGT_CTRL  = 3'd5
  } tgt_e;

  typedef struct packed {
    logic main_ps;
    logic high;
    logic ov60;
    logic keep40;
    logic keep50;
    logic rom_lo;
    logic rom_hi;
  } map_cfg_t;

  function automatic logic [ADDR_W-1:0] main_ofs(input logic high,
                                                 input logic [BANK_W-1:0] bank,
                                                 input logic [OFF_W-1:0] off);
    if (high) return {2'b00, bank[5:0], off};
    return {2'b00, bank[6:0], off[14:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] rom_ofs(input logic [BANK_W-1:0] bank,
                                                input logic [OFF_W-1:0] off);
    return {4'b0000, bank[4:0], off[14:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] psram_ofs(input logic [BANK_W-1:0] bank,
                                                  input logic [OFF_W-1:0] off,
                                                  input int aw);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << aw) - ADDR_W'(1);
    return {bank, off} & mask;
  endfunction

  function automatic logic [ADDR_W-1:0] sram_ofs(input logic [BANK_W-1:0] bank,
                                                 input logic [OFF_W-1:0] off);
    return {9'd0, bank[2:0], off[11:0]};
  endfunction
endpackage

// File: rtl/cbm_ctrl_regs.sv
module cbm_ctrl_regs
  import cbm_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata,
  output map_cfg_t         cfg_q,
  output logic             commit_evt
);
  localparam logic [IDX_W-1:0] COMMIT_IDX = IDX_W'(14);
  localparam map_cfg_t CFG_RST = '{main_ps: 1'b0, high: 1'b0, ov60: 1'b0,
                                   keep40: 1'b0, keep50: 1'b0,
                                   rom_lo: 1'b1, rom_hi: 1'b1};

  logic [DW-1:0] stg_q [NREG];
  map_cfg_t      cfg_nxt;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [DW-1:0] RV = (gi == 7 || gi == 8) ? (DW'(1) << KEY_BIT) : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 stg_q[gi] <= RV;
      else if (wr_en && widx == IDX_W'(gi))       stg_q[gi] <= wdata;
    end
  end

  assign commit_evt = wr_en && (widx == COMMIT_IDX) && wdata[KEY_BIT];

  always_comb begin
    cfg_nxt.main_ps = stg_q[1][KEY_BIT];
    cfg_nxt.high    = stg_q[2][KEY_BIT];
    cfg_nxt.ov60    = stg_q[3][KEY_BIT];
    cfg_nxt.keep40  = stg_q[5][KEY_BIT];
    cfg_nxt.keep50  = stg_q[6][KEY_BIT];
    cfg_nxt.rom_lo  = stg_q[7][KEY_BIT];
    cfg_nxt.rom_hi  = stg_q[8][KEY_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= CFG_RST;
    else if (commit_evt) cfg_q <= cfg_nxt;
  end

  assign rdata = stg_q[ridx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stg_q[$past(widx)] == $past(wdata)); // R1
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit_evt) |=> $stable(cfg_q)); // R2
  AST_COMMIT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (cfg_q.main_ps == $past(stg_q[1][KEY_BIT]) &&
                    cfg_q.rom_hi  == $past(stg_q[8][KEY_BIT]))); // R3
endmodule

// File: rtl/cbm_window.sv
module cbm_window
  import cbm_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  output logic              hit_reg,
  output logic              hit_sram,
  output logic [IDX_W-1:0]  reg_idx
);
  assign hit_reg  = (bank < BANK_W'(NREG)) && (off == REG_WIN_OFF);
  assign hit_sram = (bank[7:3] == SRAM_BANK_HI) && (off[15:12] == SRAM_OFF_HI);
  assign reg_idx  = bank[IDX_W-1:0];
endmodule

// File: rtl/cbm_layout.sv
module cbm_layout
  import cbm_pkg::*;
#(
  parameter int PSRAM_AW = 19
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  input  map_cfg_t          cfg,
  output tgt_e              sel,
  output logic [ADDR_W-1:0] ofs
);
  logic upper;
  logic hit_main, hit_ov60, hit_40, hit_50, hit_rlo, hit_rhi, hit_fix;
  logic lin_bank, full_bank, mirror_bank;
  tgt_e main_src;
  logic [ADDR_W-1:0] ps_ofs;

  assign upper       = off[15];
  assign lin_bank    = (bank <= 8'h7D) || bank[7];
  assign full_bank   = (bank >= 8'h40 && bank <= 8'h7D) || (bank >= 8'hC0);
  assign mirror_bank = !bank[6];
  assign hit_main    = cfg.high ? (full_bank || (mirror_bank && upper))
                                : (lin_bank && upper);
  assign hit_ov60    = cfg.ov60    && (bank[7:4] == 4'h6);
  assign hit_40      = !cfg.keep40 && (bank[7:4] == 4'h4);
  assign hit_50      = !cfg.keep50 && (bank[7:4] == 4'h5);
  assign hit_rlo     = cfg.rom_lo  && (bank[7:5] == 3'b000) && upper;
  assign hit_rhi     = cfg.rom_hi  && (bank[7:5] == 3'b100) && upper;
  assign hit_fix     = ((bank[7:5] == 3'b001) && (off[15:13] == 3'b011)) ||
                       (bank[7:3] == 5'b01110);
  assign main_src    = cfg.main_ps ? TGT_PSRAM : TGT_FLASH;
  assign ps_ofs      = psram_ofs(bank, off, PSRAM_AW);

  always_comb begin
    sel = TGT_NONE;
    ofs = '0;
    if (hit_main) begin
      sel = main_src;
      ofs = cfg.main_ps ? ps_ofs : main_ofs(cfg.high, bank, off);
    end
    if (hit_ov60 || hit_40 || hit_50) begin
      sel = TGT_PSRAM;
      ofs = ps_ofs;
    end
    if (hit_rlo || hit_rhi) begin
      sel = TGT_ROM;
      ofs = rom_ofs(bank, off);
    end
    if (hit_fix) begin
      sel = TGT_PSRAM;
      ofs = ps_ofs;
    end
  end
endmodule

// File: rtl/cbm_mapper.sv
module cbm_mapper
  import cbm_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int DW       = 8,
  parameter int PSRAM_AW = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [23:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [2:0]        tgt_sel,
  output logic [23:0]       tgt_ofs,
  output logic [DW-1:0]     reg_rdata
);
  localparam int IDX_W = $clog2(NREG);

  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic              hit_reg, hit_sram, commit_evt;
  logic [IDX_W-1:0]  reg_idx;
  logic [DW-1:0]     reg_val;
  map_cfg_t          cfg_q;
  tgt_e              map_sel;
  logic [ADDR_W-1:0] map_ofs;

  assign bank = bus_addr[23:16];
  assign off  = bus_addr[15:0];

  cbm_window #(.NREG(NREG), .IDX_W(IDX_W)) u_win (
    .bank(bank), .off(off), .hit_reg(hit_reg), .hit_sram(hit_sram), .reg_idx(reg_idx)
  );

  cbm_ctrl_regs #(.NREG(NREG), .DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit_reg), .widx(reg_idx),
    .wdata(bus_wdata), .ridx(reg_idx), .rdata(reg_val), .cfg_q(cfg_q),
    .commit_evt(commit_evt)
  );

  cbm_layout #(.PSRAM_AW(PSRAM_AW)) u_map (
    .bank(bank), .off(off), .cfg(cfg_q), .sel(map_sel), .ofs(map_ofs)
  );

  always_comb begin
    if (hit_reg) begin
      tgt_sel = TGT_CTRL;
      tgt_ofs = ADDR_W'(reg_idx);
    end else if (hit_sram) begin
      tgt_sel = TGT_SRAM;
      tgt_ofs = sram_ofs(bank, off);
    end else begin
      tgt_sel = map_sel;
      tgt_ofs = map_ofs;
    end
  end

  assign reg_rdata = hit_reg ? reg_val : '0;

  AST_FIXED_PSRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[23:19] == 5'b01110) |-> (tgt_sel == TGT_PSRAM)); // R11
  AST_PSRAM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel == TGT_PSRAM) |-> (tgt_ofs < (ADDR_W'(1) << PSRAM_AW))); // R13
  AST_ROM_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel == TGT_ROM) |-> bus_addr[15]); // R10
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel == TGT_NONE) |-> (tgt_ofs == '0)); // R12
endmodule

// File: tb/tb_cbm_mapper.sv
module tb_cbm_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [2:0]  tgt_sel;
  logic [23:0] tgt_ofs;
  logic [7:0]  reg_rdata;
  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  cbm_mapper dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .tgt_sel(tgt_sel), .tgt_ofs(tgt_ofs), .reg_rdata(reg_rdata)
  );

  // {req, addr, expected select, expected offset} for the layout left by reset
  localparam int NV = 22;
  localparam logic [54:0] VEC [NV] = '{
    {4'd10, 24'h008000, 3'd3, 24'h000000}, // R10
    {4'd10, 24'h1FFFFF, 3'd3, 24'h0FFFFF}, // R10
    {4'd7,  24'h208000, 3'd1, 24'h100000}, // R7
    {4'd11, 24'h206000, 3'd2, 24'h006000}, // R11
    {4'd11, 24'h3F7FFF, 3'd2, 24'h077FFF}, // R11
    {4'd12, 24'h205FFF, 3'd0, 24'h000000}, // R12
    {4'd9,  24'h451234, 3'd2, 24'h051234}, // R9
    {4'd13, 24'h5AABCD, 3'd2, 24'h02ABCD}, // R13
    {4'd7,  24'h608000, 3'd1, 24'h300000}, // R7
    {4'd12, 24'h601000, 3'd0, 24'h000000}, // R12
    {4'd11, 24'h740042, 3'd2, 24'h040042}, // R11
    {4'd12, 24'h7E8000, 3'd0, 24'h000000}, // R12
    {4'd10, 24'h808000, 3'd3, 24'h000000}, // R10
    {4'd7,  24'hA09000, 3'd1, 24'h101000}, // R7
    {4'd7,  24'hFFFFFF, 3'd1, 24'h3FFFFF}, // R7
    {4'd5,  24'h125ABC, 3'd4, 24'h002ABC}, // R5
    {4'd5,  24'h175FFF, 3'd4, 24'h007FFF}, // R5
    {4'd12, 24'h185000, 3'd0, 24'h000000}, // R12
    {4'd12, 24'h104FFF, 3'd0, 24'h000000}, // R12
    {4'd12, 24'h005001, 3'd0, 24'h000000}, // R12
    {4'd7,  24'h7D8000, 3'd1, 24'h3E8000}, // R7
    {4'd12, 24'hC00000, 3'd0, 24'h000000}  // R12
  };

  task automatic look(input int r, input logic [23:0] a,
                      input logic [2:0] es, input logic [23:0] eo);
    @(negedge clk);
    bus_addr = a;
    bus_wr = 1'b0;
    #1;
    nvec++;
    if (tgt_sel !== es || tgt_ofs !== eo) begin
      nbad++;
      $display("FAIL R%0d addr %h: sel %0d ofs %h, expected sel %0d ofs %h",
               r, a, tgt_sel, tgt_ofs, es, eo);
    end
  endtask

  task automatic rd(input int r, input logic [3:0] idx, input logic [7:0] ed);
    @(negedge clk);
    bus_addr = {4'h0, idx, 16'h5000};
    bus_wr = 1'b0;
    #1;
    nvec++;
    if (tgt_sel !== 3'd5 || tgt_ofs !== {20'd0, idx} || reg_rdata !== ed) begin
      nbad++;
      $display("FAIL R%0d reg %0d: sel %0d ofs %h data %h, expected sel 5 ofs %h data %h",
               r, idx, tgt_sel, tgt_ofs, reg_rdata, {20'd0, idx}, ed);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    nbad++;
    $display("FAIL watchdog: run did not complete, actual hung, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R4: reset register values
    rd(4, 4'h0, 8'h00);
    rd(4, 4'h7, 8'h80);
    rd(4, 4'h8, 8'h80);
    rd(4, 4'hE, 8'h00);

    for (int i = 0; i < NV; i++)
      look(int'(VEC[i][54:51]), VEC[i][50:27], VEC[i][26:24], VEC[i][23:0]);

    // R1 / R2: staging a high layout does not change the decode
    wr(24'h025000, 8'h80);
    rd(1, 4'h2, 8'h80);
    look(2, 24'hC01234, 3'd0, 24'h000000);
    // R3: commit, then the high layout is live
    wr(24'h0E5000, 8'h80);
    look(8, 24'hC01234, 3'd1, 24'h001234);   // R8
    look(8, 24'h3F8000, 3'd1, 24'h3F8000);   // R8
    look(8, 24'h7E0000, 3'd0, 24'h000000);   // R8
    look(10, 24'h008000, 3'd3, 24'h000000);  // R10 overrides main

    // R9 / R10: overlays off, linear layout
    wr(24'h025000, 8'h00);
    wr(24'h035000, 8'h80);
    wr(24'h055000, 8'h80);
    wr(24'h065000, 8'h80);
    wr(24'h075000, 8'h00);
    wr(24'h085000, 8'h00);
    wr(24'h0E5000, 8'h80);
    look(9, 24'h451234, 3'd0, 24'h000000);   // R9
    look(9, 24'h459234, 3'd1, 24'h229234);   // R9
    look(9, 24'h5F0000, 3'd0, 24'h000000);   // R9
    look(9, 24'h630010, 3'd2, 24'h030010);   // R9
    look(10, 24'h008000, 3'd1, 24'h000000);  // R10
    look(10, 24'h9FFFFF, 3'd1, 24'h0FFFFF);  // R10

    // R6: PSRAM as main program target
    wr(24'h015000, 8'h80);
    wr(24'h0E5000, 8'h80);
    look(6, 24'h208000, 3'd2, 24'h008000);   // R6

    // R3: register 0x0E with bit 7 clear does not commit
    wr(24'h015000, 8'h00);
    wr(24'h0E5000, 8'h7F);
    look(3, 24'h208000, 3'd2, 24'h008000);   // R3

    // R14: writes outside the register window
    wr(24'h015001, 8'hFF);
    wr(24'h105000, 8'hFF);
    wr(24'h208000, 8'hFF);
    rd(14, 4'h1, 8'h00);
    rd(14, 4'h0, 8'h00);
    rd(14, 4'hE, 8'h7F);

    // R4: reset in mid-run restores registers and mapping
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(4, 4'h2, 8'h00);
    rd(4, 4'h8, 8'h80);
    look(4, 24'h008000, 3'd3, 24'h000000);   // R4
    look(4, 24'h451234, 3'd2, 24'h051234);   // R4

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule